// File: doc/BRIEF.md
# Receiver link synchronization request controller

This block drives the active-low synchronization request line of a multi-lane serial converter receiver. After reset it holds the request low. Each link-clock cycle every lane reports whether its character was the /K/ comma. Each enabled lane counts the /K/ characters it sees in a row. When every enabled lane has reached the threshold, the block releases the request.

The `subclass_i` input selects the release rule. Subclass 0 releases as soon as the comma count is complete. Subclasses 1 and 2 also require a rising edge of the synchronized SYSREF input since the last reset, so that release never follows a free-running multiframe count. SYSREF is synchronized with two flops, and a sticky flag records its first rising edge. Once the line is released it stays high until reset or an explicit resync request. Error flags never touch the line. Any error raises a sticky interrupt, which a one-cycle clear strobe removes.

Top module: `rx_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, `sync_n_o` is 0, `irq_o` is 0 and `state_o` shows the reset state.
- R2: After reset is released, `sync_n_o` stays 0 until every enabled lane has flagged `K_THRESH` consecutive /K/ characters while in the wait-for-comma state.
- R3: On a lane, a cycle without its /K/ flag before the threshold restarts that lane's count from zero.
- R4: With `subclass_i` = 0, `sync_n_o` rises exactly `K_THRESH`+2 clock edges after reset release when all lanes flag /K/ from the release onwards. The first edge leaves the reset state.
- R5: With `subclass_i` = 1, a complete comma count without any SYSREF rising edge since reset parks the block in the wait-for-SYSREF state with `sync_n_o` low. A one-cycle SYSREF pulse then raises `sync_n_o` on the fourth edge after the pulse is applied.
- R6: Any nonzero `subclass_i`, including 2, follows the same release rule as subclass 1.
- R7: A SYSREF pulse seen while reset is active does not count. A SYSREF edge after release but before the comma count is complete does count, and then release is as fast as in subclass 0.
- R8: A lane whose `lane_en_i` bit is 0 takes no part in the comma check.
- R9: Once high, `sync_n_o` stays high regardless of /K/ flags. It falls only on reset or on `resync_i`, which returns the block to the wait-for-comma state with fresh counts.
- R10: Any bit of `err_i` high at a clock edge sets `irq_o` after that edge, and `sync_n_o` is unaffected.
- R11: `irq_o` stays high until an `irq_clr_i` strobe. A new error in the same cycle as the strobe keeps it high.
- R12: `state_o` is one-hot: 4'b0001 reset, 4'b0010 waiting for commas, 4'b0100 waiting for SYSREF, 4'b1000 synchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| subclass_i | input | 2 | Release rule select (0, or nonzero needing SYSREF) |
| lane_en_i | input | LANES | Lanes taking part in the comma check |
| k_flag_i | input | LANES | Per-lane flag: this cycle's character is /K/ |
| sysref_i | input | 1 | Asynchronous SYSREF input |
| err_i | input | ERR_W | Error flags from the receive datapath |
| resync_i | input | 1 | Request to drop synchronization and restart |
| irq_clr_i | input | 1 | Clear strobe for the interrupt |
| sync_n_o | output | 1 | Active-low synchronization request |
| irq_o | output | 1 | Sticky error interrupt |
| state_o | output | 4 | One-hot controller state |

## Verification
The hardest situations to reach from the ports involve the order of SYSREF and the comma count. These are a SYSREF edge that arrives before the count finishes, and a SYSREF pulse given while reset is still active. The stimulus covers each of them with its own scenario. In one, SYSREF is pulsed on the release cycle itself. In another, SYSREF is pulsed inside the reset window and the bench confirms the block parks waiting for SYSREF. Separate scenarios break a lane's comma run one character short of the threshold, and fire an error and a clear strobe in the same cycle.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'b0001,
        ST_WAIT_K  = 4'b0010,
        ST_WAIT_SR = 4'b0100,
        ST_SYNCED  = 4'b1000
    } sync_state_e;

    typedef struct packed {
        sync_state_e state;
        logic        sync_n;
        logic        irq;
    } ctrl_regs_t;

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
        logic seen;
    } sr_regs_t;

endpackage

// File: rtl/rx_sync_kcnt.sv
module rx_sync_kcnt #(
    parameter int LANES    = 4,
    parameter int K_THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [LANES-1:0] lane_en,
    input  logic [LANES-1:0] k_flag,
    output logic             all_done
);
    localparam int CW = $clog2(K_THRESH + 1);
    localparam logic [CW-1:0] K_MAX = CW'(K_THRESH);

    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (!count_en || !k_flag[g]) begin
                cnt_d = '0;
            end else if (cnt_q != K_MAX) begin
                cnt_d = cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign lane_ok[g] = (cnt_q == K_MAX) || !lane_en[g];
    end

    assign all_done = &lane_ok;

endmodule

// File: rtl/rx_sync_sysref.sv
module rx_sync_sysref
    import rx_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_i,
    output logic seen_o
);
    sr_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = sysref_i;
        r_d.sync = r_q.meta;
        r_d.prev = r_q.sync;
        if (r_q.sync && !r_q.prev) begin
            r_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign seen_o = r_q.seen;

endmodule

// File: rtl/rx_sync_ctrl.sv
module rx_sync_ctrl
    import rx_sync_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int K_THRESH = 4,
    parameter int ERR_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       subclass_i,
    input  logic [LANES-1:0] lane_en_i,
    input  logic [LANES-1:0] k_flag_i,
    input  logic             sysref_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic             resync_i,
    input  logic             irq_clr_i,
    output logic             sync_n_o,
    output logic             irq_o,
    output logic [3:0]       state_o
);
    ctrl_regs_t c_d, c_q;
    logic       k_done;
    logic       sr_seen;
    logic       count_en;
    logic       need_sr;

    assign count_en = (c_q.state == ST_WAIT_K) && !resync_i;
    assign need_sr  = (subclass_i != 2'd0);

    rx_sync_kcnt #(
        .LANES    (LANES),
        .K_THRESH (K_THRESH)
    ) u_kcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .lane_en  (lane_en_i),
        .k_flag   (k_flag_i),
        .all_done (k_done)
    );

    rx_sync_sysref u_sysref (
        .clk      (clk),
        .rst_n    (rst_n),
        .sysref_i (sysref_i),
        .seen_o   (sr_seen)
    );

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_RESET: begin
                c_d.state = ST_WAIT_K;
            end
            ST_WAIT_K: begin
                if (!resync_i && k_done) begin
                    c_d.state = (!need_sr || sr_seen) ? ST_SYNCED : ST_WAIT_SR;
                end
            end
            ST_WAIT_SR: begin
                if (resync_i)     c_d.state = ST_WAIT_K;
                else if (sr_seen) c_d.state = ST_SYNCED;
            end
            ST_SYNCED: begin
                if (resync_i) c_d.state = ST_WAIT_K;
            end
            default: begin
                c_d.state = ST_RESET;
            end
        endcase
        c_d.sync_n = (c_d.state == ST_SYNCED);
        c_d.irq    = (|err_i) || (c_q.irq && !irq_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_RESET, sync_n: 1'b0, irq: 1'b0};
        else        c_q <= c_d;
    end

    assign sync_n_o = c_q.sync_n;
    assign irq_o    = c_q.irq;
    assign state_o  = c_q.state;

endmodule

// File: rtl/rx_sync_ctrl_chk.sv
module rx_sync_ctrl_chk #(
    parameter int ERR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       subclass_i,
    input logic             sysref_i,
    input logic [ERR_W-1:0] err_i,
    input logic             resync_i,
    input logic             irq_clr_i,
    input logic             sync_n_o,
    input logic             irq_o,
    input logic [3:0]       state_o
);
    logic sr_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_hi_q <= 1'b0;
        else if (sysref_i) sr_hi_q <= 1'b1;
    end

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |-> !sync_n_o); // R1

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_o)); // R12

    AST_SR_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_n_o) && subclass_i != 2'd0) |-> sr_hi_q); // R5

    AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n_o && !resync_i) |=> sync_n_o); // R9

    AST_ERR_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_i) |=> irq_o); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o); // R11

endmodule

bind rx_sync_ctrl rx_sync_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .subclass_i (subclass_i),
    .sysref_i   (sysref_i),
    .err_i      (err_i),
    .resync_i   (resync_i),
    .irq_clr_i  (irq_clr_i),
    .sync_n_o   (sync_n_o),
    .irq_o      (irq_o),
    .state_o    (state_o)
);

// File: tb/tb_rx_sync_ctrl.sv
module tb_rx_sync_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int K_THRESH   = 4;
    localparam int ERR_W      = 4;

    localparam logic [3:0] S_RST = 4'b0001;
    localparam logic [3:0] S_WK  = 4'b0010;
    localparam logic [3:0] S_WSR = 4'b0100;
    localparam logic [3:0] S_SYN = 4'b1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       subclass_i = '0;
    logic [LANES-1:0] lane_en_i = '1;
    logic [LANES-1:0] k_flag_i = '0;
    logic             sysref_i = 1'b0;
    logic [ERR_W-1:0] err_i = '0;
    logic             resync_i = 1'b0;
    logic             irq_clr_i = 1'b0;
    logic             sync_n_o;
    logic             irq_o;
    logic [3:0]       state_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_sync_ctrl #(.LANES(LANES), .K_THRESH(K_THRESH), .ERR_W(ERR_W)) dut (
        .clk(clk), .rst_n(rst_n), .subclass_i(subclass_i), .lane_en_i(lane_en_i),
        .k_flag_i(k_flag_i), .sysref_i(sysref_i), .err_i(err_i), .resync_i(resync_i),
        .irq_clr_i(irq_clr_i), .sync_n_o(sync_n_o), .irq_o(irq_o), .state_o(state_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Holds reset for three cycles with quiet inputs, then releases it on a falling edge.
    task automatic start(input logic [1:0] sc, input logic [LANES-1:0] en);
        rst_n = 1'b0; k_flag_i = '0; sysref_i = 1'b0; err_i = '0;
        resync_i = 1'b0; irq_clr_i = 1'b0;
        subclass_i = sc; lane_en_i = en;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; err_i = '1; k_flag_i = '1;
        step(2);
        check("R1 sync_n in reset", 32'(sync_n_o), 0);
        check("R1 irq in reset", 32'(irq_o), 0);
        check("R12 reset state code", 32'(state_o), 32'(S_RST));
        err_i = '0;
    endtask

    task automatic t_sub0();
        start(2'd0, '1);
        k_flag_i = '1;
        step(1);
        check("R12 wait-comma code", 32'(state_o), 32'(S_WK));
        step(K_THRESH);
        check("R2 low before threshold edge", 32'(sync_n_o), 0);
        step(1);
        check("R4 release at K+2 edges", 32'(sync_n_o), 1);
        check("R12 synced code", 32'(state_o), 32'(S_SYN));
    endtask

    task automatic t_break();
        start(2'd0, '1);
        k_flag_i = '1;
        step(1 + K_THRESH - 1);
        k_flag_i = 4'b1011;
        step(1);
        k_flag_i = '1;
        step(K_THRESH);
        check("R3 count restarted after miss", 32'(sync_n_o), 0);
        step(1);
        check("R3 release after fresh run", 32'(sync_n_o), 1);
    endtask

    task automatic t_lane_en();
        start(2'd0, 4'b0011);
        k_flag_i = 4'b0011;
        step(K_THRESH + 2);
        check("R8 disabled lanes ignored", 32'(sync_n_o), 1);
    endtask

    task automatic t_sub1();
        start(2'd1, '1);
        k_flag_i = '1;
        step(K_THRESH + 12);
        check("R5 held low without SYSREF", 32'(sync_n_o), 0);
        check("R12 wait-sysref code", 32'(state_o), 32'(S_WSR));
        sysref_i = 1'b1;
        step(1);
        sysref_i = 1'b0;
        step(2);
        check("R5 low during SYSREF pipeline", 32'(sync_n_o), 0);
        step(1);
        check("R5 release after SYSREF edge", 32'(sync_n_o), 1);
    endtask

    task automatic t_sub2_early();
        start(2'd2, '1);
        k_flag_i = '1;
        sysref_i = 1'b1;
        step(1);
        sysref_i = 1'b0;
        step(K_THRESH);
        check("R7 early SYSREF low before threshold", 32'(sync_n_o), 0);
        step(1);
        check("R6 subclass 2 release with early SYSREF", 32'(sync_n_o), 1);
    endtask

    task automatic t_sysref_in_reset();
        rst_n = 1'b0; subclass_i = 2'd1; lane_en_i = '1; k_flag_i = '0;
        sysref_i = 1'b1;
        step(2);
        sysref_i = 1'b0;
        step(2);
        rst_n = 1'b1;
        k_flag_i = '1;
        step(K_THRESH + 8);
        check("R7 SYSREF in reset ignored", 32'(sync_n_o), 0);
        check("R7 parked waiting SYSREF", 32'(state_o), 32'(S_WSR));
    endtask

    task automatic t_resync();
        start(2'd0, '1);
        k_flag_i = '1;
        step(K_THRESH + 2);
        k_flag_i = '0;
        step(10);
        check("R9 stays high without commas", 32'(sync_n_o), 1);
        resync_i = 1'b1;
        step(1);
        resync_i = 1'b0;
        check("R9 resync drops line", 32'(sync_n_o), 0);
        check("R9 resync to wait-comma", 32'(state_o), 32'(S_WK));
        step(5);
        check("R9 low without commas after resync", 32'(sync_n_o), 0);
        k_flag_i = '1;
        step(K_THRESH);
        check("R9 fresh count needed", 32'(sync_n_o), 0);
        step(1);
        check("R9 release after fresh count", 32'(sync_n_o), 1);
    endtask

    task automatic t_irq();
        start(2'd0, '1);
        k_flag_i = '1;
        step(K_THRESH + 2);
        check("R11 irq idle", 32'(irq_o), 0);
        err_i = 4'b0100;
        step(1);
        err_i = '0;
        check("R10 irq set by error", 32'(irq_o), 1);
        check("R10 sync_n unaffected by error", 32'(sync_n_o), 1);
        step(5);
        check("R11 irq sticky", 32'(irq_o), 1);
        irq_clr_i = 1'b1;
        step(1);
        irq_clr_i = 1'b0;
        check("R11 irq cleared", 32'(irq_o), 0);
        err_i = 4'b0001; irq_clr_i = 1'b1;
        step(1);
        err_i = '0; irq_clr_i = 1'b0;
        check("R11 set wins over clear", 32'(irq_o), 1);
        check("R10 sync_n still high", 32'(sync_n_o), 1);
    endtask

    initial begin
        step(1);
        t_reset();
        t_sub0();
        t_break();
        t_lane_en();
        t_sub1();
        t_sub2_early();
        t_sysref_in_reset();
        t_resync();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule